// File: doc/BRIEF.md
# Bounded-Timeout Watchdog with Periodic Reset

This block guards a system with two independent reset timers that share one reset output. The first is a watchdog countdown. Each time software feeds it, the countdown is reloaded with the smallest of three limits. The first limit is a ceiling fixed by a build-time parameter. The second is a timeout that software may request at will. The third is a software cap that can only be lowered. A reset of the system is the only way to raise the cap again.

The second timer is a periodic reset counter. It runs at all times, and feeding the watchdog does not stop or extend it. Software can read how many cycles remain before the periodic reset. Software can also ask for a reset at once through an early-request strobe.

Any of the three reset sources drives the reset output high for one cycle. In the same edge, every limit and counter returns to its reset value. A two-bit code records which source caused the most recent reset, and this code survives the internal reset. The external reset is asynchronous and active low. Its release passes through a two-flop synchronizer before the counters begin to run.

Top module: `wdog_bounded`

## Requirements
- R1: A parameter HW_MAX sets the longest possible watchdog timeout. A requested time larger than HW_MAX still yields a timeout of HW_MAX.
- R2: After any reset, the requested time and the software cap both equal HW_MAX. A feed with no writes in between therefore gives a timeout of HW_MAX.
- R3: A feed loads the countdown with min(HW_MAX, cap, requested time). If no further feed arrives, rst_o rises at the clock edge T+1 edges after the feed edge, where T is the loaded value. A feed given while the count is zero still prevents the reset.
- R4: A write to the requested time is accepted at any moment, whether the new value is larger or smaller. The new value applies from the next feed. A written value of zero is stored as one.
- R5: A write to the cap is taken only when the new value is below the current cap. A larger value is ignored. A written value of zero is stored as one.
- R6: The periodic timer produces a reset pulse every PERIOD+1 cycles whatever the feed activity.
- R7: per_left_o shows the periodic cycles remaining. It equals PERIOD in the cycle that rst_o is high, and it then falls by one per cycle.
- R8: An early request drives rst_o high in the following cycle.
- R9: Every reset pulse returns the requested time, the cap, the watchdog count and the periodic count to their reset values.
- R10: cause_o reads 2'b00 after the external reset. Otherwise it holds the source of the latest pulse: 2'b01 for the watchdog, 2'b10 for the periodic timer, 2'b11 for an early request. The periodic timer wins over the watchdog, and the watchdog wins over an early request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| feed_i | input | 1 | Watchdog feed strobe |
| req_we_i | input | 1 | Requested-time write strobe |
| req_data_i | input | CW | Requested-time value |
| cap_we_i | input | 1 | Software-cap write strobe |
| cap_data_i | input | CW | Software-cap value |
| early_i | input | 1 | Immediate reset request |
| per_left_o | output | PW | Periodic cycles remaining |
| rst_o | output | 1 | One-cycle reset pulse |
| cause_o | output | 2 | Source of the latest reset |

## Verification
rst_o is a register whose input is the combined trigger. An early request therefore shows on rst_o one edge later. A feed that loads T shows rst_o T+1 edges after the feed edge. The bench drives every strobe on a falling edge. It then counts falling edges until rst_o is first seen high, and compares that count with T+2 for a feed or 1 for an early request. cause_o and per_left_o are sampled on the same falling edge as the pulse. This is the edge at which they have just taken their post-reset values. The periodic interval is taken as the distance between two pulses, so it does not depend on reset-release latency.

// File: rtl/wdb_pkg.sv
package wdb_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_WDOG   = 2'b01,
    CAUSE_PERIOD = 2'b10,
    CAUSE_EARLY  = 2'b11
  } cause_e;
endpackage

// File: rtl/wdb_limits.sv
module wdb_limits #(
  parameter int CW     = 16,
  parameter int HW_MAX = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          req_we_i,
  input  logic [CW-1:0] req_data_i,
  input  logic          cap_we_i,
  input  logic [CW-1:0] cap_data_i,
  output logic [CW-1:0] reload_o
);
  localparam logic [CW-1:0] HW  = CW'(HW_MAX);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] req_q, req_d, cap_q, cap_d;
  logic [CW-1:0] req_w, cap_w, lim;

  // zero is never stored: it becomes one tick
  assign req_w = (req_data_i == '0) ? ONE : req_data_i;
  assign cap_w = (cap_data_i == '0) ? ONE : cap_data_i;

  always_comb begin
    req_d = req_q;
    cap_d = cap_q;
    if (clr_i) begin
      req_d = HW;
      cap_d = HW;
    end else begin
      if (req_we_i) req_d = req_w;
      if (cap_we_i && (cap_w < cap_q)) cap_d = cap_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= HW;
      cap_q <= HW;
    end else begin
      req_q <= req_d;
      cap_q <= cap_d;
    end
  end

  always_comb begin
    lim      = (cap_q < req_q) ? cap_q : req_q;
    reload_o = (lim < HW) ? lim : HW;
  end

  assert_cap_ratchet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cap_q <= $past(cap_q));
  assert_reload_ceiling_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o <= HW);
  assert_reload_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o != '0);
  assert_clr_restores_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (req_q == HW) && (cap_q == HW));
endmodule

// File: rtl/wdb_countdown.sv
module wdb_countdown #(
  parameter int CW     = 16,
  parameter int HW_MAX = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          feed_i,
  input  logic [CW-1:0] reload_i,
  output logic          expire_o
);
  localparam logic [CW-1:0] HW = CW'(HW_MAX);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)              cnt_d = HW;
    else if (feed_i)        cnt_d = reload_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= HW;
    else         cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == '0) && !feed_i;

  assert_feed_loads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_i && !clr_i) |=> cnt_q == $past(reload_i));
  assert_count_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feed_i && !clr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/wdb_period.sv
module wdb_period #(
  parameter int PERIOD = 1000,
  parameter int PW     = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [PW-1:0] left_o,
  output logic          expire_o
);
  localparam logic [PW-1:0] FULL = PW'(PERIOD);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)             cnt_d = FULL;
    else if (cnt_q != '0)  cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= FULL;
    else         cnt_q <= cnt_d;
  end

  assign left_o   = cnt_q;
  assign expire_o = (cnt_q == '0);

  assert_period_steps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - PW'(1));
  assert_period_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
endmodule

// File: rtl/wdog_bounded.sv
module wdog_bounded #(
  parameter int CW     = 16,
  parameter int HW_MAX = 40,
  parameter int PERIOD = 1000,
  parameter int PW     = $clog2(PERIOD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          feed_i,
  input  logic          req_we_i,
  input  logic [CW-1:0] req_data_i,
  input  logic          cap_we_i,
  input  logic [CW-1:0] cap_data_i,
  input  logic          early_i,
  output logic [PW-1:0] per_left_o,
  output logic          rst_o,
  output logic [1:0]    cause_o
);
  import wdb_pkg::*;

  logic [1:0]    sync_q;
  logic          rst_sync_n;
  logic [CW-1:0] reload;
  logic          wd_exp, per_exp, trig;
  logic          rst_q, rst_d;
  cause_e        cause_q, cause_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  wdb_limits #(.CW(CW), .HW_MAX(HW_MAX)) u_limits (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .clr_i(trig),
    .req_we_i(req_we_i), .req_data_i(req_data_i),
    .cap_we_i(cap_we_i), .cap_data_i(cap_data_i),
    .reload_o(reload)
  );

  wdb_countdown #(.CW(CW), .HW_MAX(HW_MAX)) u_count (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .clr_i(trig),
    .feed_i(feed_i), .reload_i(reload), .expire_o(wd_exp)
  );

  wdb_period #(.PERIOD(PERIOD), .PW(PW)) u_period (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .clr_i(trig),
    .left_o(per_left_o), .expire_o(per_exp)
  );

  assign trig = per_exp | wd_exp | early_i;

  always_comb begin
    rst_d   = trig;
    cause_d = cause_q;
    if (per_exp)      cause_d = CAUSE_PERIOD;
    else if (wd_exp)  cause_d = CAUSE_WDOG;
    else if (early_i) cause_d = CAUSE_EARLY;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rst_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      rst_q   <= rst_d;
      cause_q <= cause_d;
    end
  end

  assign rst_o   = rst_q;
  assign cause_o = cause_q;

  assert_early_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    early_i |=> rst_o);
  assert_pulse_reloads_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    rst_o |-> per_left_o == PW'(PERIOD));
  assert_pulse_has_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    rst_o |-> cause_o != CAUSE_NONE);
endmodule

// File: tb/wdog_bounded_test.sv
module wdog_bounded_test;
  localparam int CW  = 16;
  localparam int HW  = 40;
  localparam int PER = 1000;
  localparam int PW  = $clog2(PER + 1);

  logic          clk = 1'b0;
  logic          rst_n, feed, req_we, cap_we, early;
  logic [CW-1:0] req_data, cap_data;
  logic [PW-1:0] per_left;
  logic          rst_out;
  logic [1:0]    cause;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  always #2.5 clk = ~clk;

  wdog_bounded #(.CW(CW), .HW_MAX(HW), .PERIOD(PER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .feed_i(feed),
    .req_we_i(req_we), .req_data_i(req_data),
    .cap_we_i(cap_we), .cap_data_i(cap_data),
    .early_i(early), .per_left_o(per_left),
    .rst_o(rst_out), .cause_o(cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hard_reset();
    rst_n = 1'b0; feed = 0; req_we = 0; cap_we = 0; early = 0;
    req_data = '0; cap_data = '0;
    repeat (3) @(negedge clk);
    check(rst_out == 1'b0, "R9 reset rst_o", rst_out, 0);
    check(cause == 2'b00, "R10 reset cause", cause, 0);
    check(per_left == PW'(PER), "R7 reset per_left", per_left, PER);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_req(input int v);
    req_we = 1'b1; req_data = CW'(v);
    @(negedge clk);
    req_we = 1'b0;
  endtask

  task automatic wr_cap(input int v);
    cap_we = 1'b1; cap_data = CW'(v);
    @(negedge clk);
    cap_we = 1'b0;
  endtask

  // feed now, count falling edges until rst_o is seen: expect T+2
  task automatic feed_expect(input int t, input string req);
    int n = 0;
    feed = 1'b1;
    while (n < t + 10) begin
      @(negedge clk);
      feed = 1'b0;
      n++;
      if (rst_out) break;
    end
    check(n == t + 2, req, n, t + 2);
  endtask

  task automatic t_default();
    hard_reset();
    feed_expect(HW, "R2 default timeout");
    check(cause == 2'b01, "R10 watchdog cause", cause, 1);
  endtask

  task automatic t_request();
    hard_reset();
    wr_req(12);
    feed_expect(12, "R3 requested timeout");
    wr_req(100);
    feed_expect(HW, "R1 ceiling over request");
    wr_req(0);
    feed_expect(1, "R4 zero request");
  endtask

  task automatic t_cap();
    hard_reset();
    wr_cap(20);
    wr_cap(30);
    feed_expect(20, "R5 raise ignored");
    wr_cap(15);
    wr_req(30);
    wr_req(5);
    feed_expect(5, "R3 min of limits");
    feed_expect(HW, "R9 limits restored");
    wr_cap(0);
    feed_expect(1, "R5 zero cap");
  endtask

  task automatic t_early();
    hard_reset();
    wr_cap(8);
    early = 1'b1;
    @(negedge clk);
    early = 1'b0;
    check(rst_out == 1'b1, "R8 early pulse", rst_out, 1);
    check(cause == 2'b11, "R10 early cause", cause, 3);
    check(per_left == PW'(PER), "R9 periodic reloaded", per_left, PER);
    @(negedge clk);
    check(rst_out == 1'b0, "R8 single pulse", rst_out, 0);
    repeat (3) @(negedge clk);
    check(cause == 2'b11, "R10 cause held", cause, 3);
    feed_expect(HW, "R9 cap restored after early");
  endtask

  task automatic t_periodic();
    int n;
    hard_reset();
    feed = 1'b1;
    n = 0;
    while (!rst_out && n < PER + 20) begin
      @(negedge clk);
      n++;
    end
    check(rst_out == 1'b1, "R6 periodic fired", rst_out, 1);
    check(cause == 2'b10, "R10 periodic cause", cause, 2);
    check(per_left == PW'(PER), "R7 left at pulse", per_left, PER);
    @(negedge clk);
    check(per_left == PW'(PER - 1), "R7 left decrements", per_left, PER - 1);
    n = 1;
    while (!rst_out && n < PER + 20) begin
      @(negedge clk);
      n++;
    end
    check(n == PER + 1, "R6 interval with feeding", n, PER + 1);
    n = 0;
    while (per_left != '0 && n < PER + 20) begin
      @(negedge clk);
      n++;
    end
    early = 1'b1;
    @(negedge clk);
    early = 1'b0;
    check(rst_out == 1'b1, "R10 collision pulse", rst_out, 1);
    check(cause == 2'b10, "R10 periodic over early", cause, 2);
    feed = 1'b0;
  endtask

  initial begin
    t_default();
    t_request();
    t_cap();
    t_early();
    t_periodic();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule